// File: doc/BRIEF.md
# Stereo serial audio register and FIFO front end

This block sits between a simple register bus and the serial shifter of a stereo audio link. Software uses it to program the link: enable, bit clock direction, justification format, record and playback disables, internal loopback and a clock divider value. It moves audio words through two 16-entry FIFOs. Each FIFO word carries a left and a right sample. A single data address serves both directions: a write pushes into the transmit FIFO and a read pops the receive FIFO. The shifter and the clock generator are outside the block. The shifter takes transmit words over a valid/ready stream and delivers receive words over a second valid/ready stream.

Each FIFO has a programmable service threshold that drives a request output. An underrun or overrun event sets a sticky error flag. Software clears each flag by writing a one to its bit in the clear word. One interrupt output combines the service requests and the error flags through a mask. A soft reset bit in the control word flushes both FIFOs and returns every register to zero in one cycle.

Stream rules. On the transmit side, `tx_valid` is high only while playback is active and the FIFO holds a word. A word leaves the FIFO on each cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` while the FIFO is empty counts as a request that could not be served. On the receive side, the shifter cannot stall. `rx_ready` only says that recording is active. A word offered while the FIFO is full is dropped and reported, and the block applies no back-pressure.

Top module: `audio_link_front`

## Requirements
- R1: Register map, by byte offset. 0x00 control: bit0 link enable, bit2 bit clock drive, bit3 soft reset (reads 0), bits 11:8 transmit threshold, bits 15:12 receive threshold. 0x04 format: bit0 left-justified, bit3 record off, bit4 playback off, bit5 loopback. 0x14 mask at bits 6:3. 0x60 divider, low 7 bits. Each register reads back what was written. The status word (0x0C) and the clear word (0x18) ignore their stored value, and 0x18 and unmapped offsets read 0. `link_en`, `bclk_out`, `left_just` and `clk_div` mirror the matching fields.
- R2: A write to the data offset 0x80 pushes the write data into the transmit FIFO (16 words). If the FIFO is full at that edge, the word is dropped and the FIFO is unchanged.
- R3: A read of 0x80 returns the oldest receive word and pops it. If the receive FIFO is empty, the read returns 0 and nothing changes.
- R4: `tx_valid` is high when link enable is 1, playback off is 0 and the transmit FIFO is not empty. `tx_word` is the oldest word. A word is removed on each cycle where `tx_valid` and `tx_ready` are both high.
- R5: `rx_ready` is high when link enable is 1, record off is 0 and loopback is 0. A word offered with `rx_valid` and `rx_ready` high is stored if the receive FIFO is not full. If the FIFO is full, the word is dropped and the overrun flag (status bit 6) is set.
- R6: When playback is active, `tx_ready` is high and the transmit FIFO is empty, the underrun flag (status bit 5) is set.
- R7: Both error flags hold until software writes a 1 to bit 5 (underrun) or bit 6 (overrun) of the clear word. A new event in the same cycle as the clear leaves the flag set.
- R8: `tx_req` (status bit 3) is high while the transmit level is at or below the transmit threshold. `rx_req` (status bit 4) is high while the receive level is at or above the receive threshold.
- R9: Status bits: bit0 transmit FIFO not full, bit1 receive FIFO not empty, bit2 busy, bit3 and bit4 the service requests, bit5 underrun, bit6 overrun, bit7 off.
- R10: `irq` is the OR over status bits 3 to 6, each ANDed with mask bit 3 to 6.
- R11: A control write with bit 3 set flushes both FIFOs. It clears control, format, mask, divider and both flags at that edge, and the rest of that write is ignored.
- R12: When loopback is on, every word that leaves the transmit FIFO is offered to the receive FIFO, under the same full and overrun rules. The external receive stream is then ignored.
- R13: Busy is high while link enable is 1 or `frame_active` is high. Off is high only when both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Shifter takes or requests a word |
| tx_word | output | 2*SAMPLE_W | Oldest transmit word |
| rx_valid | input | 1 | Shifter offers a receive word |
| rx_ready | output | 1 | Recording active from the external stream |
| rx_word | input | 2*SAMPLE_W | Receive word |
| frame_active | input | 1 | Shifter still moving a frame |
| link_en | output | 1 | Link enable field |
| bclk_out | output | 1 | Drive bit clock out |
| left_just | output | 1 | Left-justified format selected |
| clk_div | output | DIV_W | Divider value for the clock generator |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong FIFO level or a wrong pointer shows up on the next clock. The bench sees it as a changed `tx_req`, `rx_req` or `tx_valid`, or as a wrong `tx_word`. A receive pointer fault appears at the next data read. A sticky flag that is lost or set falsely changes `irq` in the following cycle whenever its mask bit is set. A status read reports it at once. The bench compares every output against a queue model on every clock, so a divergence is caught within one cycle of the moment it becomes visible at a pin.

// File: rtl/audio_link_pkg.sv
package audio_link_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_FMT  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h14;
  localparam logic [7:0] OFS_CLR  = 8'h18;
  localparam logic [7:0] OFS_DIV  = 8'h60;
  localparam logic [7:0] OFS_DATA = 8'h80;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_BCLK = 2;
  localparam int unsigned CTL_SRST = 3;
  localparam int unsigned CTL_TXTH = 8;
  localparam int unsigned CTL_RXTH = 12;
  localparam int unsigned TH_W     = 4;

  localparam int unsigned FMT_ALT    = 0;
  localparam int unsigned FMT_NOREC  = 3;
  localparam int unsigned FMT_NOPLAY = 4;
  localparam int unsigned FMT_LOOP   = 5;

  localparam int unsigned ST_TXNF  = 0;
  localparam int unsigned ST_RXNE  = 1;
  localparam int unsigned ST_BUSY  = 2;
  localparam int unsigned ST_TXREQ = 3;
  localparam int unsigned ST_RXREQ = 4;
  localparam int unsigned ST_URUN  = 5;
  localparam int unsigned ST_OVR   = 6;
  localparam int unsigned ST_OFF   = 7;
  localparam int unsigned IRQ_SRCS = 4;

  typedef struct packed {
    logic [TH_W-1:0] rx_th;
    logic [TH_W-1:0] tx_th;
    logic            bclk_out;
    logic            en;
  } ctrl_t;

  typedef struct packed {
    logic loop;
    logic no_play;
    logic no_rec;
    logic alt;
  } fmt_t;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/link_csr.sv
module link_csr
  import audio_link_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 7,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [7:0]        stat_word,
  input  logic [WORD_W-1:0] rx_head,
  input  logic              rx_empty,
  input  logic              set_urun,
  input  logic              set_ovr,
  output ctrl_t             ctrl,
  output fmt_t              fmt,
  output logic [IRQ_SRCS-1:0] irq_mask,
  output logic [DIV_W-1:0]  div,
  output logic              urun,
  output logic              ovr,
  output logic              soft_rst,
  output logic              data_wr,
  output logic              data_rd,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic wr_ctrl, wr_fmt, wr_mask, wr_clr, wr_div, rd_any;
  logic clr_urun, clr_ovr;
  logic unused_wbits;

  assign rd_any   = bus_sel && !bus_wr;
  assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_fmt   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_FMT));
  assign wr_mask  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_clr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_div   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
  assign data_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign data_rd  = rd_any && (bus_addr == ADDR_W'(OFS_DATA));
  assign soft_rst = wr_ctrl && bus_wdata[CTL_SRST];
  assign clr_urun = wr_clr && bus_wdata[ST_URUN];
  assign clr_ovr  = wr_clr && bus_wdata[ST_OVR];
  assign unused_wbits = ^{bus_wdata[BUS_W-1:16], bus_wdata[7:6], bus_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      fmt      <= '0;
      irq_mask <= '0;
      div      <= '0;
      urun     <= 1'b0;
      ovr      <= 1'b0;
    end else if (soft_rst) begin
      ctrl     <= '0;
      fmt      <= '0;
      irq_mask <= '0;
      div      <= '0;
      urun     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en       <= bus_wdata[CTL_EN];
        ctrl.bclk_out <= bus_wdata[CTL_BCLK];
        ctrl.tx_th    <= bus_wdata[CTL_TXTH +: TH_W];
        ctrl.rx_th    <= bus_wdata[CTL_RXTH +: TH_W];
      end
      if (wr_fmt) begin
        fmt.alt     <= bus_wdata[FMT_ALT];
        fmt.no_rec  <= bus_wdata[FMT_NOREC];
        fmt.no_play <= bus_wdata[FMT_NOPLAY];
        fmt.loop    <= bus_wdata[FMT_LOOP];
      end
      if (wr_mask) irq_mask <= bus_wdata[ST_TXREQ +: IRQ_SRCS];
      if (wr_div)  div      <= bus_wdata[DIV_W-1:0];
      urun <= set_urun | (urun & !clr_urun);
      ovr  <= set_ovr  | (ovr  & !clr_ovr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL): bus_rdata = BUS_W'({ctrl.rx_th, ctrl.tx_th, 5'b0,
                                               ctrl.bclk_out, 1'b0, ctrl.en});
        ADDR_W'(OFS_FMT):  bus_rdata = BUS_W'({fmt.loop, fmt.no_play, fmt.no_rec,
                                               2'b0, fmt.alt});
        ADDR_W'(OFS_STAT): bus_rdata = BUS_W'(stat_word);
        ADDR_W'(OFS_MASK): bus_rdata = BUS_W'({irq_mask, 3'b0});
        ADDR_W'(OFS_DIV):  bus_rdata = BUS_W'(div);
        ADDR_W'(OFS_DATA): bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
        default:           bus_rdata = '0;
      endcase
    end
  end

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr && !soft_rst) |=> ovr);
  p_urun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !clr_urun && !soft_rst) |=> urun);
endmodule

// File: rtl/link_status.sv
module link_status
  import audio_link_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_on,
  input  logic                frame_active,
  input  logic [LW-1:0]       tx_level,
  input  logic [LW-1:0]       rx_level,
  input  logic [TH_W-1:0]     tx_th,
  input  logic [TH_W-1:0]     rx_th,
  input  logic                urun,
  input  logic                ovr,
  input  logic [IRQ_SRCS-1:0] irq_mask,
  output logic [7:0]          stat_word,
  output logic                tx_req,
  output logic                rx_req,
  output logic                irq
);
  logic [IRQ_SRCS-1:0] term;
  logic busy;

  assign busy   = link_on | frame_active;
  assign tx_req = (tx_level <= LW'(tx_th));
  assign rx_req = (rx_level >= LW'(rx_th));

  always_comb begin
    stat_word           = '0;
    stat_word[ST_TXNF]  = (tx_level != LW'(DEPTH));
    stat_word[ST_RXNE]  = (rx_level != '0);
    stat_word[ST_BUSY]  = busy;
    stat_word[ST_TXREQ] = tx_req;
    stat_word[ST_RXREQ] = rx_req;
    stat_word[ST_URUN]  = urun;
    stat_word[ST_OVR]   = ovr;
    stat_word[ST_OFF]   = !busy;
  end

  for (genvar g = 0; g < IRQ_SRCS; g++) begin : g_src
    assign term[g] = stat_word[ST_TXREQ + g] & irq_mask[g];
  end
  assign irq = |term;

  p_off_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[ST_OFF] |-> (!link_on && !frame_active));
endmodule

// File: rtl/audio_link_front.sv
module audio_link_front
  import audio_link_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DIV_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [2*SAMPLE_W-1:0] tx_word,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [2*SAMPLE_W-1:0] rx_word,
  input  logic                  frame_active,
  output logic                  link_en,
  output logic                  bclk_out,
  output logic                  left_just,
  output logic [DIV_W-1:0]      clk_div,
  output logic                  tx_req,
  output logic                  rx_req,
  output logic                  irq
);
  localparam int unsigned WORD_W = 2 * SAMPLE_W;
  localparam int unsigned LW     = $clog2(DEPTH + 1);

  ctrl_t               ctrl;
  fmt_t                fmt;
  logic [IRQ_SRCS-1:0] irq_mask;
  logic                urun, ovr, soft_rst, data_wr, data_rd;
  logic [7:0]          stat_word;
  logic [WORD_W-1:0]   tx_head, rx_head, rx_src_word;
  logic [LW-1:0]       tx_level, rx_level;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic                play_on, rec_on, tx_fire, tx_push, rx_pop, rx_push;
  logic                rx_src_valid, set_urun, set_ovr;

  assign play_on  = ctrl.en & !fmt.no_play;
  assign rec_on   = ctrl.en & !fmt.no_rec;
  assign tx_valid = play_on & !tx_empty;
  assign tx_word  = tx_head;
  assign tx_fire  = tx_valid & tx_ready;
  assign set_urun = play_on & tx_ready & tx_empty;
  assign tx_push  = data_wr & !tx_full;

  assign rx_ready     = rec_on & !fmt.loop;
  assign rx_src_valid = fmt.loop ? tx_fire : rx_valid;
  assign rx_src_word  = fmt.loop ? tx_head : rx_word;
  assign rx_push      = rec_on & rx_src_valid & !rx_full;
  assign set_ovr      = rec_on & rx_src_valid & rx_full;
  assign rx_pop       = data_rd & !rx_empty;

  assign link_en   = ctrl.en;
  assign bclk_out  = ctrl.bclk_out;
  assign left_just = fmt.alt;

  link_csr #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .WORD_W(WORD_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_word(stat_word),
    .rx_head(rx_head), .rx_empty(rx_empty), .set_urun(set_urun),
    .set_ovr(set_ovr), .ctrl(ctrl), .fmt(fmt), .irq_mask(irq_mask),
    .div(clk_div), .urun(urun), .ovr(ovr), .soft_rst(soft_rst),
    .data_wr(data_wr), .data_rd(data_rd), .bus_rdata(bus_rdata)
  );

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst), .push(tx_push),
    .wdata(bus_wdata[WORD_W-1:0]), .pop(tx_fire), .head(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst), .push(rx_push),
    .wdata(rx_src_word), .pop(rx_pop), .head(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  link_status #(.DEPTH(DEPTH), .LW(LW)) u_stat (
    .clk(clk), .rst_n(rst_n), .link_on(ctrl.en), .frame_active(frame_active),
    .tx_level(tx_level), .rx_level(rx_level), .tx_th(ctrl.tx_th),
    .rx_th(ctrl.rx_th), .urun(urun), .ovr(ovr), .irq_mask(irq_mask),
    .stat_word(stat_word), .tx_req(tx_req), .rx_req(rx_req), .irq(irq)
  );

  p_tx_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_full && !tx_fire && !soft_rst) |=> (tx_level == $past(tx_level)));
  p_rx_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && rx_empty) |-> (bus_rdata == '0));
  p_rx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ovr && !rx_pop && !soft_rst) |=> (rx_level == $past(rx_level)));
  p_urun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_urun && !soft_rst) |=> urun);
  p_srst_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_level == '0 && rx_level == '0 && !ctrl.en && !urun && !ovr));
endmodule

// File: tb/sim_audio_link_front.sv
module sim_audio_link_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic txr = 1'b0, rxv = 1'b0, fa = 1'b0;
  logic [31:0] rxd = '0;

  logic [31:0] rdata, txw;
  logic txv, rxrdy, len, bclk, lj, treq, rreq, irq;
  logic [6:0] cdiv;

  int compared = 0;
  int mism = 0;
  string cur = "R1";

  logic [31:0] m_txq[$];
  logic [31:0] m_rxq[$];
  bit m_en, m_bclk, m_alt, m_norec, m_noplay, m_loop, m_tur, m_ror;
  bit [3:0] m_tth, m_rth, m_mask;
  bit [6:0] m_div;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_link_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tx_valid(txv), .tx_ready(txr),
    .tx_word(txw), .rx_valid(rxv), .rx_ready(rxrdy), .rx_word(rxd),
    .frame_active(fa), .link_en(len), .bclk_out(bclk), .left_just(lj),
    .clk_div(cdiv), .tx_req(treq), .rx_req(rreq), .irq(irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s [%s] %s actual=%h expected=%h", tag, cur, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = '0;
    s[0] = m_txq.size() < 16;
    s[1] = m_rxq.size() > 0;
    s[2] = m_en | fa;
    s[3] = m_txq.size() <= int'(m_tth);
    s[4] = m_rxq.size() >= int'(m_rth);
    s[5] = m_tur;
    s[6] = m_ror;
    s[7] = !(m_en | fa);
    return s;
  endfunction

  task automatic compare_all();
    logic [7:0] st;
    logic [31:0] er;
    bit play, rec;
    play = m_en && !m_noplay;
    rec  = m_en && !m_norec;
    st = m_status();
    chk("R4", "tx_valid", 32'(txv), 32'(play && m_txq.size() > 0));
    if (play && m_txq.size() > 0) chk("R4", "tx_word", txw, m_txq[0]);
    chk("R5", "rx_ready", 32'(rxrdy), 32'(rec && !m_loop));
    chk("R1", "link_en", 32'(len), 32'(m_en));
    chk("R1", "bclk_out", 32'(bclk), 32'(m_bclk));
    chk("R1", "left_just", 32'(lj), 32'(m_alt));
    chk("R1", "clk_div", 32'(cdiv), 32'(m_div));
    chk("R8", "tx_req", 32'(treq), 32'(st[3]));
    chk("R8", "rx_req", 32'(rreq), 32'(st[4]));
    chk("R10", "irq", 32'(irq), 32'(|(st[6:3] & m_mask)));
    if (sel && !wr) begin
      case (addr)
        8'h00: er = {16'b0, m_rth, m_tth, 5'b0, m_bclk, 1'b0, m_en};
        8'h04: er = {26'b0, m_loop, m_noplay, m_norec, 2'b0, m_alt};
        8'h0C: er = {24'b0, st};
        8'h14: er = {25'b0, m_mask, 3'b0};
        8'h60: er = {25'b0, m_div};
        8'h80: er = (m_rxq.size() > 0) ? m_rxq[0] : 32'h0;
        default: er = 32'h0;
      endcase
      chk(addr == 8'h80 ? "R3" : (addr == 8'h0C ? "R9" : "R1"), "bus_rdata", rdata, er);
    end
  endtask

  task automatic model_edge();
    bit play, rec, fire, su, so, src_v, rfull;
    logic [31:0] tw, src_d;
    play = m_en && !m_noplay;
    rec  = m_en && !m_norec;
    if (sel && wr && addr == 8'h00 && wdata[3]) begin
      m_txq.delete(); m_rxq.delete();
      {m_en, m_bclk, m_alt, m_norec, m_noplay, m_loop, m_tur, m_ror} = '0;
      m_tth = 0; m_rth = 0; m_mask = 0; m_div = 0;
      return;
    end
    fire = play && m_txq.size() > 0 && txr;
    tw = fire ? m_txq[0] : 32'h0;
    su = play && txr && m_txq.size() == 0;
    src_v = m_loop ? fire : rxv;
    src_d = m_loop ? tw : rxd;
    rfull = m_rxq.size() >= 16;
    so = rec && src_v && rfull;
    if (sel && !wr && addr == 8'h80 && m_rxq.size() > 0) void'(m_rxq.pop_front());
    if (fire) void'(m_txq.pop_front());
    if (sel && wr && addr == 8'h80 && m_txq.size() + (fire ? 1 : 0) < 16)
      m_txq.push_back(wdata);
    if (rec && src_v && !rfull) m_rxq.push_back(src_d);
    if (sel && wr && addr == 8'h18) begin
      if (wdata[5]) m_tur = 0;
      if (wdata[6]) m_ror = 0;
    end
    if (su) m_tur = 1;
    if (so) m_ror = 1;
    if (sel && wr && addr == 8'h00) begin
      m_en = wdata[0]; m_bclk = wdata[2]; m_tth = wdata[11:8]; m_rth = wdata[15:12];
    end
    if (sel && wr && addr == 8'h04) begin
      m_alt = wdata[0]; m_norec = wdata[3]; m_noplay = wdata[4]; m_loop = wdata[5];
    end
    if (sel && wr && addr == 8'h14) m_mask = wdata[6:3];
    if (sel && wr && addr == 8'h60) m_div = wdata[6:0];
  endtask

  task automatic step();
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    step();
    sel = 0; wr = 0;
  endtask

  task automatic bread(input logic [7:0] a);
    sel = 1; wr = 0; addr = a;
    step();
    sel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mism++;
    $display("FAIL watchdog [%s] actual=hung expected=done", cur);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state and status word
    cur = "R9";
    idle(1);
    bread(8'h0C);
    bread(8'h00);
    // R1: programming and readback
    cur = "R1";
    bwrite(8'h00, 32'hFFFF_E1F4);
    bwrite(8'h04, 32'h0000_0001);
    bwrite(8'h60, 32'h0000_008C);
    bwrite(8'h14, 32'hFFFF_FFFF);
    bwrite(8'h0C, 32'hFFFF_FFFF);
    bwrite(8'h18, 32'h0000_0000);
    for (int a = 0; a < 8; a++) bread(8'(a * 4));
    bread(8'h14); bread(8'h18); bread(8'h60); bread(8'h40);
    // R10: mask only transmit request, then all
    cur = "R10";
    bwrite(8'h14, 32'h0000_0008);
    idle(1);
    bwrite(8'h14, 32'h0000_0078);
    // R2: fill transmit FIFO past its depth while link is off
    cur = "R2";
    for (int i = 0; i < 18; i++) begin
      bwrite(8'h80, 32'hA000_0000 + 32'(i));
      bread(8'h0C);
    end
    // R4: enable link and drain with a gapped ready pattern
    cur = "R4";
    bwrite(8'h00, 32'h0000_E105);
    for (int i = 0; i < 40; i++) begin
      txr = (i % 3) != 1;
      step();
    end
    // R6: ready kept high with empty FIFO sets underrun
    cur = "R6";
    txr = 1; idle(2); txr = 0;
    bread(8'h0C);
    // R7: clear with a simultaneous event keeps it set, plain clear removes it
    cur = "R7";
    txr = 1; bwrite(8'h18, 32'h0000_0020); txr = 0;
    bread(8'h0C);
    bwrite(8'h18, 32'h0000_0060);
    bread(8'h0C);
    // R5: receive stream beyond depth causes overrun
    cur = "R5";
    rxv = 1;
    for (int i = 0; i < 19; i++) begin
      rxd = 32'hB000_0000 + 32'(i);
      step();
    end
    rxv = 0;
    bread(8'h0C);
    // R3: pop all words, then reads of an empty FIFO return zero
    cur = "R3";
    rxv = 1; rxd = 32'hC0DE_0001;
    bread(8'h80);
    rxv = 0;
    for (int i = 0; i < 18; i++) bread(8'h80);
    bwrite(8'h18, 32'h0000_0040);
    // R8: thresholds at several levels
    cur = "R8";
    bwrite(8'h00, 32'h0000_3201);
    for (int i = 0; i < 4; i++) begin
      rxd = 32'hD000_0000 + 32'(i);
      rxv = 1; step(); rxv = 0;
      bwrite(8'h80, 32'hE000_0000 + 32'(i));
    end
    for (int i = 0; i < 5; i++) bread(8'h80);
    // R5: recording disabled ignores the stream
    cur = "R5";
    bwrite(8'h04, 32'h0000_0008);
    rxv = 1; idle(3); rxv = 0;
    bread(8'h0C); bread(8'h80);
    // R12: loopback moves transmit words into the receive FIFO
    cur = "R12";
    bwrite(8'h04, 32'h0000_0020);
    for (int i = 0; i < 6; i++) bwrite(8'h80, 32'h5500_0000 + 32'(i));
    rxv = 1; rxd = 32'hDEAD_BEEF;
    txr = 1; idle(8); txr = 0; rxv = 0;
    for (int i = 0; i < 7; i++) bread(8'h80);
    // R13: busy and off follow frame_active with link disabled
    cur = "R13";
    bwrite(8'h00, 32'h0000_0000);
    bread(8'h0C);
    fa = 1; bread(8'h0C); fa = 0;
    bread(8'h0C);
    // R11: soft reset clears everything
    cur = "R11";
    bwrite(8'h00, 32'h0000_1105);
    bwrite(8'h04, 32'h0000_0001);
    bwrite(8'h60, 32'h0000_0012);
    for (int i = 0; i < 3; i++) bwrite(8'h80, 32'h7700_0000 + 32'(i));
    rxv = 1; rxd = 32'h1234_5678; step(); rxv = 0;
    bwrite(8'h00, 32'h0000_F10D);
    for (int a = 0; a < 8; a++) bread(8'(a * 4));
    bread(8'h14); bread(8'h60); bread(8'h80);
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule